// File: doc/BRIEF.md
# LZSS Match Result Selector

This block sits behind the comparator array of a sliding-window LZSS compressor. During one search it receives one match length per dictionary start position, in position order. It keeps the longest length seen so far and the position where that length first appeared. When the length for the final position arrives, it emits one codeword and the distance by which the window has to move before the next search begins.

If the best length is at least a configurable minimum, the codeword is a pointer codeword. It has a set flag bit, the winning position and the length, and the window moves by that length. Otherwise the codeword is a literal codeword. It has a cleared flag bit and the first lookahead symbol, and the window moves by one. A start pulse loads the lookahead symbol and clears the search. Closing a search also clears the running best, so consecutive searches never share state.

Top module: `lzss_match_selector`

## Requirements
- R1: While reset is asserted and after it is released, `cw_ready`, `cw_out` and `shift_out` are all zero until the first search completes.
- R2: `cw_ready` goes high for exactly one cycle, in the cycle after the beat (`len_valid` high) that carries position POS_COUNT-1. It is low at every other time.
- R3: The running best is replaced only when an incoming length is strictly greater than it. A tie therefore keeps the earliest position.
- R4: A pointer codeword has bit CW_W-1 set, the winning position in bits [PTR_W+LEN_W-1:LEN_W], the best length in bits [LEN_W-1:0], and zeros in all other bits. With the defaults CW_W=9, PTR_W=3 and LEN_W=3.
- R5: If the best length of a search is below MIN_MATCH (default 2), including an all-zero search, the codeword is a literal. Bit CW_W-1 is clear, bits [SYM_W-1:0] hold the symbol loaded by `start`, the remaining bits are zero, and `shift_out` is 1.
- R6: For a pointer codeword, `shift_out` equals the best length.
- R7: A `start` pulse loads `first_sym` and abandons any partial search. Lengths seen before it have no effect on the next codeword.
- R8: Cycles with `len_valid` low do not advance the position, so gaps between beats do not change the result.
- R9: After a codeword is produced, the next search begins with a best length of 0 and position 0, even without a `start` pulse. The loaded symbol is kept.
- R10: `cw_out` and `shift_out` hold their value between `cw_ready` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search and load the lookahead symbol |
| first_sym | input | SYM_W | First lookahead symbol |
| len_valid | input | 1 | A match length for the next position is present |
| len_in | input | LEN_W | Match length at the current position |
| cw_ready | output | 1 | One-cycle pulse: codeword and shift are new |
| cw_out | output | CW_W | Pointer or literal codeword |
| shift_out | output | LEN_W | Number of symbols the window must advance |

## Verification
All three results are due exactly one cycle after the beat that carries position POS_COUNT-1. The final length takes part in the comparison combinationally and is registered together with the codeword, shift and pulse. The bench drives every input on the falling edge. It reads the codeword on the falling edge that follows the rising edge which registers that last beat. On the next falling edge it confirms that the pulse has dropped and that the outputs have held. While a search is in progress, `cw_ready` is sampled on each falling edge to confirm that no pulse appears early.

// File: rtl/lzss_sel_pkg.sv
package lzss_sel_pkg;

  typedef enum logic {
    CW_LITERAL = 1'b0,
    CW_POINTER = 1'b1
  } cw_kind_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lzss_pos_counter.sv
module lzss_pos_counter #(
  parameter int POS_COUNT = 8,
  parameter int PTR_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [PTR_W-1:0] beat_pos,
  output logic             beat_last
);
  localparam logic [PTR_W-1:0] LAST_POS = PTR_W'(POS_COUNT - 1);

  logic [PTR_W-1:0] count_q;
  logic [PTR_W-1:0] count_d;
  logic             count_en;

  // position that the beat in this cycle belongs to
  always_comb begin
    beat_pos  = clear ? '0 : count_q;
    beat_last = (beat_pos == LAST_POS);
    count_en  = clear | step;
    count_d   = beat_pos;
    if (step) begin
      count_d = beat_last ? '0 : beat_pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/lzss_best_tracker.sv
module lzss_best_tracker #(
  parameter int PTR_W = 3,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             close,
  input  logic [LEN_W-1:0] len_in,
  input  logic [PTR_W-1:0] pos_in,
  output logic [LEN_W-1:0] best_len,
  output logic [PTR_W-1:0] best_ptr
);
  logic [LEN_W-1:0] len_q;
  logic [PTR_W-1:0] ptr_q;
  logic [LEN_W-1:0] base_len;
  logic [PTR_W-1:0] base_ptr;
  logic             take;
  logic             upd_en;
  logic [LEN_W-1:0] len_d;
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    base_len = clear ? '0 : len_q;
    base_ptr = clear ? '0 : ptr_q;
    take     = step && (len_in > base_len);
    best_len = take ? len_in : base_len;
    best_ptr = take ? pos_in : base_ptr;
    upd_en   = clear | step;
    if (step && close) begin
      len_d = '0;
      ptr_d = '0;
    end else begin
      len_d = best_len;
      ptr_d = best_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      ptr_q <= '0;
    end else if (upd_en) begin
      len_q <= len_d;
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/lzss_cw_packer.sv
module lzss_cw_packer
  import lzss_sel_pkg::*;
#(
  parameter int PTR_W     = 3,
  parameter int LEN_W     = 3,
  parameter int SYM_W     = 8,
  parameter int MIN_MATCH = 2,
  parameter int CW_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LEN_W-1:0] best_len,
  input  logic [PTR_W-1:0] best_ptr,
  input  logic [SYM_W-1:0] sym,
  output logic             cw_ready,
  output logic [CW_W-1:0]  cw_out,
  output logic [LEN_W-1:0] shift_out
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_MATCH);

  cw_kind_e         kind;
  logic [CW_W-1:0]  cw_d;
  logic [LEN_W-1:0] shift_d;
  logic [CW_W-1:0]  cw_q;
  logic [LEN_W-1:0] shift_q;
  logic             rdy_q;

  always_comb begin
    kind = (best_len < MIN_L) ? CW_LITERAL : CW_POINTER;
    if (kind == CW_POINTER) begin
      cw_d    = {1'b1, (CW_W-1)'({best_ptr, best_len})};
      shift_d = best_len;
    end else begin
      cw_d    = {1'b0, (CW_W-1)'(sym)};
      shift_d = LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q    <= '0;
      shift_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q <= fire;
      if (fire) begin
        cw_q    <= cw_d;
        shift_q <= shift_d;
      end
    end
  end

  assign cw_ready  = rdy_q;
  assign cw_out    = cw_q;
  assign shift_out = shift_q;
endmodule

// File: rtl/lzss_match_selector.sv
module lzss_match_selector
  import lzss_sel_pkg::*;
#(
  parameter int POS_COUNT = 8,
  parameter int LOOK_LEN  = 7,
  parameter int SYM_W     = 8,
  parameter int MIN_MATCH = 2,
  localparam int PTR_W    = $clog2(POS_COUNT),
  localparam int LEN_W    = $clog2(LOOK_LEN + 1),
  localparam int CW_W     = 1 + max2(PTR_W + LEN_W, SYM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SYM_W-1:0] first_sym,
  input  logic             len_valid,
  input  logic [LEN_W-1:0] len_in,
  output logic             cw_ready,
  output logic [CW_W-1:0]  cw_out,
  output logic [LEN_W-1:0] shift_out
);
  logic [PTR_W-1:0] beat_pos;
  logic             beat_last;
  logic             fire;
  logic [LEN_W-1:0] best_len;
  logic [PTR_W-1:0] best_ptr;
  logic [SYM_W-1:0] sym_q;
  logic [SYM_W-1:0] sym_d;

  lzss_pos_counter #(.POS_COUNT(POS_COUNT), .PTR_W(PTR_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(len_valid),
    .beat_pos(beat_pos), .beat_last(beat_last)
  );

  assign fire = len_valid & beat_last;

  lzss_best_tracker #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(len_valid), .close(beat_last),
    .len_in(len_in), .pos_in(beat_pos), .best_len(best_len), .best_ptr(best_ptr)
  );

  always_comb begin
    sym_d = start ? first_sym : sym_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q <= '0;
    end else if (start) begin
      sym_q <= sym_d;
    end
  end

  lzss_cw_packer #(
    .PTR_W(PTR_W), .LEN_W(LEN_W), .SYM_W(SYM_W), .MIN_MATCH(MIN_MATCH), .CW_W(CW_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_n), .fire(fire), .best_len(best_len), .best_ptr(best_ptr),
    .sym(sym_d), .cw_ready(cw_ready), .cw_out(cw_out), .shift_out(shift_out)
  );
endmodule

// File: rtl/lzss_match_selector_chk.sv
module lzss_match_selector_chk #(
  parameter int PTR_W     = 3,
  parameter int LEN_W     = 3,
  parameter int CW_W      = 9,
  parameter int MIN_MATCH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             len_valid,
  input logic             cw_ready,
  input logic [CW_W-1:0]  cw_out,
  input logic [LEN_W-1:0] shift_out,
  input logic [PTR_W-1:0] beat_pos,
  input logic             beat_last
);
  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (len_valid && beat_last) |=> cw_ready); // R2
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cw_ready |=> !cw_ready); // R2
  AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(len_valid && beat_last) |=> !cw_ready); // R2
  AST_LITERAL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_ready && !cw_out[CW_W-1]) |-> (shift_out == LEN_W'(1))); // R5
  AST_POINTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_ready && cw_out[CW_W-1]) |->
      (shift_out == cw_out[LEN_W-1:0] && shift_out >= LEN_W'(MIN_MATCH))); // R6
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (len_valid && !beat_last) |=> (start || beat_pos == $past(beat_pos) + 1'b1)); // R8
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!len_valid && !start) |=> (start || $stable(beat_pos))); // R8
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (len_valid && beat_last) |=> (beat_pos == '0)); // R9
  AST_CW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_ready |-> ($stable(cw_out) && $stable(shift_out))); // R10
endmodule

bind lzss_match_selector lzss_match_selector_chk #(
  .PTR_W(PTR_W), .LEN_W(LEN_W), .CW_W(CW_W), .MIN_MATCH(MIN_MATCH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .len_valid(len_valid),
  .cw_ready(cw_ready), .cw_out(cw_out), .shift_out(shift_out),
  .beat_pos(beat_pos), .beat_last(beat_last)
);

// File: tb/lzss_match_selector_test.sv
module lzss_match_selector_test;
  localparam int NPOS = 8;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [7:0] first_sym;
  logic       len_valid;
  logic [2:0] len_in;
  logic       cw_ready;
  logic [8:0] cw_out;
  logic [2:0] shift_out;

  int n_checks;
  int n_fail;

  lzss_match_selector uut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_sym(first_sym),
    .len_valid(len_valid), .len_in(len_in), .cw_ready(cw_ready),
    .cw_out(cw_out), .shift_out(shift_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0]  sym;
    logic [23:0] lens;   // position p in bits [3p+2:3p]
    logic [8:0]  exp_cw;
    logic [2:0]  exp_sh;
  } vec_t;

  // pointer codeword: {1, 00, pos[2:0], len[2:0]}; literal: {0, sym[7:0]}
  localparam vec_t VECS [5] = '{
    '{8'h41, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 9'h041, 3'd1},  // R5 all zero
    '{8'h42, {3'd0,3'd0,3'd0,3'd0,3'd3,3'd2,3'd3,3'd1}, 9'h10B, 3'd3},  // R3 tie p1/p3
    '{8'h43, {3'd7,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 9'h13F, 3'd7},  // R4 last position
    '{8'h5A, {3'd1,3'd1,3'd1,3'd1,3'd1,3'd1,3'd1,3'd1}, 9'h05A, 3'd1},  // R5 below minimum
    '{8'h44, {3'd6,3'd0,3'd1,3'd6,3'd6,3'd5,3'd5,3'd2}, 9'h11E, 3'd6}   // R6 tie p3/p4/p7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drives one search; checks that the pulse stays low until the last beat
  task automatic run_search(input logic do_start, input logic [7:0] sym,
                            input logic [23:0] lens, input int gap, input string req);
    logic early;
    early = 1'b0;
    if (do_start) begin
      start = 1'b1; first_sym = sym;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
    end
    for (int p = 0; p < NPOS; p++) begin
      len_valid = 1'b1; len_in = lens[3*p +: 3];
      @(posedge clk); @(negedge clk);
      len_valid = 1'b0;
      if (p != NPOS-1) begin
        if (cw_ready) early = 1'b1;
        for (int g = 0; g < gap; g++) begin
          @(posedge clk); @(negedge clk);
          if (cw_ready) early = 1'b1;
        end
      end
    end
    chk({req, " R2 no early pulse"}, early, 0);
  endtask

  task automatic expect_cw(input logic [8:0] cw, input logic [2:0] sh, input string req);
    chk({req, " R2 pulse"}, cw_ready, 1);
    chk({req, " codeword"}, cw_out, cw);
    chk({req, " shift"}, shift_out, sh);
    @(posedge clk); @(negedge clk);
    chk({req, " R2 pulse drops"}, cw_ready, 0);
    chk({req, " R10 codeword held"}, cw_out, cw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; first_sym = '0; len_valid = 1'b0; len_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", cw_ready, 0);
    chk("R1 codeword in reset", cw_out, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ready after reset", cw_ready, 0);
    chk("R1 shift after reset", shift_out, 0);

    foreach (VECS[i]) begin
      run_search(1'b1, VECS[i].sym, VECS[i].lens, 0, "vec");
      expect_cw(VECS[i].exp_cw, VECS[i].exp_sh, "vec R3 R4 R5 R6");
    end

    // R8: idle cycles between beats give the same result as vector 4
    run_search(1'b1, 8'h44, {3'd6,3'd0,3'd1,3'd6,3'd6,3'd5,3'd5,3'd2}, 3, "R8");
    expect_cw(9'h11E, 3'd6, "R8 gapped");

    // R7: partial search with long matches abandoned by a new start
    start = 1'b1; first_sym = 8'h11;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int p = 0; p < 3; p++) begin
      len_valid = 1'b1; len_in = 3'd7;
      @(posedge clk); @(negedge clk);
    end
    len_valid = 1'b0;
    chk("R7 no pulse on partial search", cw_ready, 0);
    run_search(1'b1, 8'h77, 24'd0, 0, "R7");
    expect_cw(9'h077, 3'd1, "R7 restart literal");

    // R9: best of 7 at p7, then a search without start sees only its own lengths
    run_search(1'b1, 8'h33, {3'd7,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 0, "R9");
    expect_cw(9'h13F, 3'd7, "R9 first");
    run_search(1'b0, 8'h00, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd2,3'd0}, 0, "R9");
    expect_cw(9'h10A, 3'd2, "R9 no carryover");
    run_search(1'b0, 8'h00, 24'd0, 0, "R9");
    expect_cw(9'h033, 3'd1, "R9 symbol kept");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule